// File: doc/BRIEF.md
# Indirect Per-Event Statistics Counter Bank

This block holds a bank of saturating counters, one for each supported link event. Lane-specific events get one counter per lane. Software reaches every counter through a two-register window.

A control word picks one counter by group, event and lane. The same word carries a command field that switches the picked counter on or off, and a status bit that shows whether the picked counter is running. A data register returns the picked counter's count.

Event pulses arrive on one flat vector with one bit per group/event/lane position. Positions that no counter uses are ignored. Register access is a plain write strobe with a combinational read: `reg_rdata` follows `reg_addr` in the same cycle.

A write to the control word takes effect at the next clock edge. The command in that word acts on the counter named by the selector fields of the same word. A counter that is switched on again after being off starts from zero.

Top module: `evtstat_bank`

## Requirements
- R1: The control word is at address 0x08 and the count register at 0x0C. Reads of any other address return 0, and writes to any other address change nothing.
- R2: Control word layout: group in bits [27:24], event in bits [23:16], lane in bits [11:8]. These three fields read back the last value written. The command field [4:2] and all other unassigned bits read 0.
- R3: Bit 7 of the control word reads 1 exactly when the counter picked by the stored selection is switched on.
- R4: Command code 3 in bits [4:2] switches on the counter named in the same write, and code 1 switches it off. Every other code leaves all counters and their on/off state unchanged.
- R5: Supported pairs are: group 0 events 0–10, group 1 events 5–13, group 2 events 0–7, group 3 events 0–5, group 4 events 0–1. For any other pair, commands have no effect, the count register reads 0 and the status bit reads 0.
- R6: Groups 0 and 4 keep an independent counter and on/off bit for each of lanes 0–3. A lane value of 4 or more selects nothing in those groups. Groups 1–3 ignore the lane field and always use lane 0.
- R7: The event for group g, event e, lane l is `evt_in[(g*16+e)*4+l]`. A lane-independent event uses its lane-0 bit only.
- R8: An enabled counter adds one at each clock edge where its event bit is high. The new value is readable in the cycle after that edge.
- R9: A counter holds at all ones instead of wrapping.
- R10: A switched-off counter holds its value and the value stays readable. A code-3 write to a switched-off counter clears it to 0. A code-3 write to a counter that is already on does not clear it.
- R11: After reset every counter is off and zero, and every selector field is 0.
- R12: An event in the same cycle as a code-3 write that turns a counter on is not counted. An event in the same cycle as a code-1 write that turns it off is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 8 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 320 | Event pulses, one bit per group/event/lane position |

## Verification
A command write and an event pulse for the same counter can fall in the same clock edge. Either the count is cleared while its event is high, or the counter is switched off while its event is high. The bench forces both cases in directed steps: it raises the counter's event bit in the very cycle of the code-3 and code-1 writes. Dense random event traffic mixed with random command writes then makes such collisions common. Each outcome is judged against a bench model that counts using the on/off state from before the write and lets the clear on a fresh switch-on take priority.

// File: rtl/evtstat_pkg.sv
`timescale 1ns/1ps
package evtstat_pkg;
  // control word field positions (decoded by software)
  localparam int GRP_LSB  = 24;
  localparam int EVT_LSB  = 16;
  localparam int LANE_LSB = 8;
  localparam int STAT_BIT = 7;
  localparam int CMD_LSB  = 2;

  localparam logic [2:0] CMD_ON  = 3'd3;
  localparam logic [2:0] CMD_OFF = 3'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;

  // supported group/event pairs
  function automatic logic evt_supported(input int g, input int e);
    case (g)
      0:       return (e >= 0) && (e <= 10);
      1:       return (e >= 5) && (e <= 13);
      2:       return (e >= 0) && (e <= 7);
      3:       return (e >= 0) && (e <= 5);
      4:       return (e >= 0) && (e <= 1);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic lane_specific(input int g);
    return (g == 0) || (g == 4);
  endfunction
endpackage

// File: rtl/evtstat_regs.sv
`timescale 1ns/1ps
module evtstat_regs
  import evtstat_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 8,
  parameter int DATA_OFS = 12,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              stat_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output sel_t              sel_o,
  output sel_t              wsel_o,
  output logic              cmd_on_o,
  output logic              cmd_off_o,
  output logic [31:0]       reg_rdata
);
  logic ctrl_hit, data_hit, ctrl_wr;
  logic [2:0] cmd;
  sel_t sel_q;

  assign ctrl_hit = (reg_addr == ADDR_W'(CTRL_OFS));
  assign data_hit = (reg_addr == ADDR_W'(DATA_OFS));
  assign ctrl_wr  = reg_wr && ctrl_hit;

  assign wsel_o.grp  = reg_wdata[GRP_LSB +: 4];
  assign wsel_o.evt  = reg_wdata[EVT_LSB +: 8];
  assign wsel_o.lane = reg_wdata[LANE_LSB +: 4];
  assign cmd         = reg_wdata[CMD_LSB +: 3];

  assign cmd_on_o  = ctrl_wr && (cmd == CMD_ON);
  assign cmd_off_o = ctrl_wr && (cmd == CMD_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= '0;
    else if (ctrl_wr) sel_q <= wsel_o;
  end

  assign sel_o = sel_q;

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) begin
      reg_rdata[GRP_LSB +: 4]  = sel_q.grp;
      reg_rdata[EVT_LSB +: 8]  = sel_q.evt;
      reg_rdata[LANE_LSB +: 4] = sel_q.lane;
      reg_rdata[STAT_BIT]      = stat_i;
    end else if (data_hit) begin
      reg_rdata[CNT_W-1:0] = cnt_i;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[15:12], reg_wdata[6:5], reg_wdata[1:0]};

  // R2: the selection changes only on a control write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> sel_q == $past(sel_q));
  // R2: a control write loads the written fields
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> sel_q == $past(wsel_o));
endmodule

// File: rtl/evtstat_seldec.sv
`timescale 1ns/1ps
module evtstat_seldec
  import evtstat_pkg::*;
#(
  parameter int GROUPS    = 5,
  parameter int EVT_SLOTS = 16,
  parameter int LANES     = 4,
  parameter int IDX_W     = 9
) (
  input  sel_t             sel,
  output logic             ok,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    int g, e, l, el, flat;
    g  = int'(sel.grp);
    e  = int'(sel.evt);
    l  = int'(sel.lane);
    el = lane_specific(g) ? l : 0;
    ok = (g < GROUPS) && (e < EVT_SLOTS) && evt_supported(g, e)
         && (!lane_specific(g) || (l < LANES));
    flat = (g * EVT_SLOTS + e) * LANES + el;
    idx  = IDX_W'(flat);
  end
endmodule

// File: rtl/evtstat_cell.sv
`timescale 1ns/1ps
module evtstat_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             on_cmd,
  input  logic             off_cmd,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      // counting uses the enable state from before this edge
      if (on_cmd && !en_q)
        cnt_q <= '0;
      else if (en_q && evt && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + CNT_W'(1);
      if (on_cmd)       en_q <= 1'b1;
      else if (off_cmd) en_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_cmd |=> !en_q);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (on_cmd && !en_q) |=> (en_q && (cnt_q == '0)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !on_cmd) |=> $stable(cnt_q));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX));
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && evt && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/evtstat_bank.sv
`timescale 1ns/1ps
module evtstat_bank
  import evtstat_pkg::*;
#(
  parameter int GROUPS    = 5,
  parameter int EVT_SLOTS = 16,
  parameter int LANES     = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int CTRL_OFS  = 8,
  parameter int DATA_OFS  = 12,
  localparam int NSLOT    = GROUPS * EVT_SLOTS * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSLOT-1:0]  evt_in
);
  localparam int IDX_W = $clog2(NSLOT);

  sel_t             sel, wsel;
  logic             cmd_on, cmd_off;
  logic             sel_ok, tgt_ok;
  logic [IDX_W-1:0] sel_idx, tgt_idx;
  logic [CNT_W-1:0] cnt_all [NSLOT];
  logic [NSLOT-1:0] en_all;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_stat;

  evtstat_regs #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_i(rd_stat), .cnt_i(rd_cnt),
    .sel_o(sel), .wsel_o(wsel), .cmd_on_o(cmd_on), .cmd_off_o(cmd_off),
    .reg_rdata(reg_rdata)
  );

  // stored selection, used for reads
  evtstat_seldec #(
    .GROUPS(GROUPS), .EVT_SLOTS(EVT_SLOTS), .LANES(LANES), .IDX_W(IDX_W)
  ) u_rdsel (.sel(sel), .ok(sel_ok), .idx(sel_idx));

  // selection carried in the write word, used for commands
  evtstat_seldec #(
    .GROUPS(GROUPS), .EVT_SLOTS(EVT_SLOTS), .LANES(LANES), .IDX_W(IDX_W)
  ) u_wrsel (.sel(wsel), .ok(tgt_ok), .idx(tgt_idx));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar e = 0; e < EVT_SLOTS; e++) begin : g_evt
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int IDX = (g * EVT_SLOTS + e) * LANES + l;
        if (evt_supported(g, e) && (lane_specific(g) || (l == 0))) begin : g_cell
          logic hit;
          assign hit = tgt_ok && (tgt_idx == IDX_W'(IDX));
          evtstat_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .evt(evt_in[IDX]),
            .on_cmd(cmd_on && hit), .off_cmd(cmd_off && hit),
            .en_o(en_all[IDX]), .cnt_o(cnt_all[IDX])
          );
        end else begin : g_none
          assign en_all[IDX]  = 1'b0;
          assign cnt_all[IDX] = '0;
        end
      end
    end
  end

  assign rd_cnt  = sel_ok ? cnt_all[sel_idx] : '0;
  assign rd_stat = sel_ok && en_all[sel_idx];

  logic unused_evt;
  assign unused_evt = ^evt_in;

  // R5: an unsupported selection reads zero from the count register
  p_unsup_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADDR_W'(DATA_OFS)) && !sel_ok) |-> (reg_rdata == '0));
  // R3: status is clear whenever the selection is unsupported
  p_unsup_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADDR_W'(CTRL_OFS)) && !sel_ok) |-> !reg_rdata[STAT_BIT]);
endmodule

// File: tb/sim_evtstat_bank.sv
`timescale 1ns/1ps
module sim_evtstat_bank;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 8;
  localparam int NSLOT      = 320;
  localparam int CMAX       = (1 << TB_CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_addr = 8'h0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NSLOT-1:0]  evt_in = '0;

  int total = 0;
  int bad = 0;

  int  m_cnt [5][16][4];
  bit  m_en  [5][16][4];
  logic [3:0] sg = '0;
  logic [7:0] se = '0;
  logic [3:0] sl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtstat_bank #(.CNT_W(TB_CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in)
  );

  function automatic bit b_sup(int g, int e);
    if (g == 0) return e <= 10;
    if (g == 1) return e >= 5 && e <= 13;
    if (g == 2) return e <= 7;
    if (g == 3) return e <= 5;
    if (g == 4) return e <= 1;
    return 1'b0;
  endfunction

  function automatic bit b_lsp(int g);
    return g == 0 || g == 4;
  endfunction

  function automatic bit b_resolve(int g, int e, int l, output int el);
    el = b_lsp(g) ? l : 0;
    return g < 5 && e < 16 && b_sup(g, e) && (!b_lsp(g) || l < 4);
  endfunction

  function automatic logic [31:0] exp_ctrl();
    int el;
    bit ok;
    logic st;
    ok = b_resolve(int'(sg), int'(se), int'(sl), el);
    st = ok ? m_en[sg][se][el] : 1'b0;
    return {4'h0, sg, se, 4'h0, sl, st, 7'h0};
  endfunction

  function automatic logic [31:0] exp_data();
    int el;
    if (!b_resolve(int'(sg), int'(se), int'(sl), el)) return 32'h0;
    return 32'(m_cnt[sg][se][el]);
  endfunction

  function automatic logic [31:0] mkw(int g, int e, int l, int cmd);
    logic [31:0] w;
    w = '0;
    w[27:24] = 4'(g);
    w[23:16] = 8'(e);
    w[11:8]  = 4'(l);
    w[4:2]   = 3'(cmd);
    return w;
  endfunction

  function automatic logic [NSLOT-1:0] evbit(int g, int e, int l);
    logic [NSLOT-1:0] v;
    v = '0;
    v[(g*16+e)*4+l] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_update(bit wr, logic [7:0] a, logic [31:0] wd, logic [NSLOT-1:0] ev);
    bit wctrl, tok;
    int tg, te, tl, tel;
    logic [2:0] cmd;
    wctrl = wr && (a == 8'h08);
    tg = int'(wd[27:24]); te = int'(wd[23:16]); tl = int'(wd[11:8]);
    cmd = wd[4:2];
    tok = wctrl && b_resolve(tg, te, tl, tel);
    for (int g = 0; g < 5; g++)
      for (int e = 0; e < 16; e++)
        for (int l = 0; l < 4; l++) begin
          if (b_sup(g, e) && (b_lsp(g) || l == 0)) begin
            bit tgt, on, off;
            tgt = tok && g == tg && e == te && l == tel;
            on  = tgt && cmd == 3'd3;
            off = tgt && cmd == 3'd1;
            if (on && !m_en[g][e][l]) m_cnt[g][e][l] = 0;
            else if (m_en[g][e][l] && ev[(g*16+e)*4+l] && m_cnt[g][e][l] < CMAX)
              m_cnt[g][e][l]++;
            if (on) m_en[g][e][l] = 1'b1;
            else if (off) m_en[g][e][l] = 1'b0;
          end
        end
    if (wctrl) begin
      sg = wd[27:24]; se = wd[23:16]; sl = wd[11:8];
    end
  endtask

  // drive one cycle, then check control word and count one cycle later
  task automatic step(bit wr, logic [7:0] a, logic [31:0] wd, logic [NSLOT-1:0] ev, string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_in = ev;
    model_update(wr, a, wd, ev);
    @(posedge clk);
    #1;
    reg_wr = 1'b0; evt_in = '0;
    reg_addr = 8'h08; #1; chk({tag, " ctrl"}, reg_rdata, exp_ctrl());
    reg_addr = 8'h0C; #1; chk({tag, " data"}, reg_rdata, exp_data());
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd5150));
    for (int g = 0; g < 5; g++)
      for (int e = 0; e < 16; e++)
        for (int l = 0; l < 4; l++) begin m_cnt[g][e][l] = 0; m_en[g][e][l] = 1'b0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(8'h08, v); chk("R11 ctrl after reset", v, 32'h0);
    rd(8'h0C, v); chk("R11 data after reset", v, 32'h0);

    // R4/R6/R7: lane 2 of group0 event0 counts only its own lane bit
    step(1, 8'h08, mkw(0, 0, 2, 3), '0, "R4");
    for (int i = 0; i < 5; i++) step(0, 8'h08, '0, evbit(0,0,2) | evbit(0,0,1), "R8");
    rd(8'h0C, v); chk("R8 lane2 count", v, 32'd5);
    step(1, 8'h08, mkw(0, 0, 1, 0), '0, "R6");
    rd(8'h0C, v); chk("R6 lane1 independent", v, 32'd0);

    // R6: lane field ignored for group 2
    step(1, 8'h08, mkw(2, 3, 3, 3), '0, "R6");
    for (int i = 0; i < 3; i++) step(0, 8'h08, '0, evbit(2,3,0) | evbit(2,3,3), "R7");
    rd(8'h0C, v); chk("R6 group2 lane ignored", v, 32'd3);
    step(1, 8'h08, mkw(2, 3, 0, 0), '0, "R6");
    rd(8'h0C, v); chk("R6 group2 lane0 same counter", v, 32'd3);

    // R4: undefined codes change nothing
    step(1, 8'h08, mkw(2, 3, 0, 5), evbit(2,3,0), "R4");
    step(1, 8'h08, mkw(2, 3, 0, 7), '0, "R4");
    rd(8'h0C, v); chk("R4 bad code no effect", v, 32'd4);

    // R12: event in the switch-off cycle is counted
    step(1, 8'h08, mkw(2, 3, 0, 1), evbit(2,3,0), "R12");
    rd(8'h0C, v); chk("R12 off-cycle event counted", v, 32'd5);
    step(0, 8'h08, '0, evbit(2,3,0), "R10");
    rd(8'h08, v); chk("R3 status off", {31'h0, v[7]}, 32'd0);
    rd(8'h0C, v); chk("R10 disabled holds", v, 32'd5);
    // R12: event in the switch-on cycle is not counted, count cleared
    step(1, 8'h08, mkw(2, 3, 0, 3), evbit(2,3,0), "R12");
    rd(8'h0C, v); chk("R12 on-cycle clear", v, 32'd0);
    step(0, 8'h08, '0, evbit(2,3,0), "R8");
    step(1, 8'h08, mkw(2, 3, 0, 3), evbit(2,3,0), "R10");
    rd(8'h0C, v); chk("R10 re-on while on keeps count", v, 32'd2);
    rd(8'h08, v); chk("R3 status on", {31'h0, v[7]}, 32'd1);

    // R5: unsupported pairs and lane out of range
    step(1, 8'h08, mkw(1, 2, 0, 3), '1, "R5");
    rd(8'h08, v); chk("R5 unsupported status", v, mkw(1, 2, 0, 0));
    rd(8'h0C, v); chk("R5 unsupported data", v, 32'd0);
    step(1, 8'h08, mkw(0, 0, 5, 3), '1, "R6");
    rd(8'h0C, v); chk("R6 lane out of range", v, 32'd0);

    // R1: other addresses
    step(1, 8'h04, mkw(0, 0, 0, 3), '0, "R1");
    rd(8'h04, v); chk("R1 other address reads zero", v, 32'd0);
    step(1, 8'h08, mkw(0, 0, 0, 0), '0, "R1");
    rd(8'h08, v); chk("R1 ignored write left counter off", {31'h0, v[7]}, 32'd0);

    // R2: unused bits and command field read back zero
    step(1, 8'h08, 32'hF3_0A_F7_FF, '0, "R2");
    rd(8'h08, v); chk("R2 readback", v, 32'h030A_0700);

    // R9: saturation on group4 event1 lane3
    step(1, 8'h08, mkw(4, 1, 3, 3), '0, "R9");
    for (int i = 0; i < CMAX + 20; i++) step(0, 8'h08, '0, evbit(4,1,3), "R9");
    rd(8'h0C, v); chk("R9 saturated", v, 32'(CMAX));

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NSLOT-1:0] ev;
      logic [31:0] wd;
      logic [7:0] a;
      int cmds [6] = '{0, 1, 3, 3, 5, 3};
      bit wr;
      for (int i = 0; i < NSLOT; i++) ev[i] = ($urandom_range(3) == 0);
      wr = ($urandom_range(2) == 0);
      a = ($urandom_range(9) == 0) ? 8'h0C : 8'h08;
      wd = $urandom;
      wd[27:24] = 4'($urandom_range(5));
      wd[23:16] = ($urandom_range(15) == 0) ? 8'($urandom) : 8'($urandom_range(15));
      wd[11:8]  = 4'($urandom_range(5));
      wd[4:2]   = 3'(cmds[$urandom_range(5)]);
      step(wr, a, wd, ev, n[0] ? "R3" : "R8");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule